// File: doc/BRIEF.md
# Reset Qualification and Watchdog Stretch Controller

This block produces the single reset that drives a microcontroller core and is also sent off-chip to reset peripherals. It has two sources. The first is an external reset line that a Schmitt trigger has already cleaned up. The second is a one-cycle overflow pulse from the watchdog timer. The external line is first brought into the clock domain by a flop synchronizer. It is then accepted only after it has stayed high for a minimum width.

The oscillator-mode select input decides how that width is measured. In the crystal mode, the width is counted in machine-cycle strobes, where one machine cycle is 12 system clocks and the default is two machine cycles. In the PLL mode, the width is counted in ticks of a free-running reference, so that it covers a fixed span of time. The default is four ticks of a 4 MHz reference, which gives 1 µs.

A watchdog overflow gives a reset pulse of a fixed number of system clocks, equal to three machine cycles. The two sources are combined into one reset. While that reset is high, the address-latch and program-fetch strobes are forced high. At all other times they follow the values the core supplies. The block has no output that clears the data RAM.

Top module: `rst_qual_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cpu_rst` and `rst_out` are low after that edge, and every width count and watchdog count is cleared.
- R2: With `osc_sel` = 0 (cycle mode), `cpu_rst` rises on the clock edge that samples the second `mc_tick` pulse seen while the synchronized reset input is high. The input passes through two synchronizer flops before it is counted.
- R3: With `osc_sel` = 1 (time mode), `cpu_rst` rises on the edge that samples the fourth `ref_tick` seen while the synchronized input is high, with the default `REF_TICKS` = 4. In this mode `mc_tick` pulses have no effect on the count.
- R4: If the reset input falls before it qualifies, the width count restarts from zero and no reset is produced.
- R5: A qualified external reset stays asserted for as long as `rst_in` stays high. It is released on the third clock edge after `rst_in` goes low: two synchronizer edges plus one register edge.
- R6: A `wdt_ovf` pulse sampled at an edge makes `cpu_rst` high from that edge for exactly 36 system clocks (3 machine cycles of 12 clocks).
- R7: A `wdt_ovf` pulse that arrives while a watchdog reset is already running restarts the 36-clock count from that edge.
- R8: `rst_out` always equals `cpu_rst`. It is high whenever the qualified external reset is high or the watchdog pulse is running.
- R9: While `cpu_rst` is high, `ale_pin` and `psen_pin` are high. Otherwise they equal `ale_core` and `psen_core`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rst_in | input | 1 | Schmitt-cleaned external reset request, asynchronous |
| osc_sel | input | 1 | 0 = width counted in machine cycles, 1 = width counted in reference ticks |
| mc_tick | input | 1 | One-clock strobe once per machine cycle |
| ref_tick | input | 1 | One-clock strobe from the free-running time reference |
| wdt_ovf | input | 1 | One-clock watchdog overflow pulse |
| ale_core | input | 1 | Address-latch strobe from the core |
| psen_core | input | 1 | Program-fetch strobe from the core |
| cpu_rst | output | 1 | Internal core reset, active high |
| rst_out | output | 1 | Reset sent to external peripherals, active high |
| ale_pin | output | 1 | Address-latch strobe after the reset override |
| psen_pin | output | 1 | Program-fetch strobe after the reset override |

## Verification
The hardest case to reach from the ports is a restart of the width count. It needs a reset request that falls after it has been partly counted, followed by a new request. The stimulus drives the tick strobes by hand, one pulse at a time. It lets one strobe be counted and then drops the input long enough for the synchronizer to see it. It then raises the input again and shows that a single strobe does not qualify, while a second one does. The watchdog restart is reached by sending a second overflow at a known cycle inside the running pulse. The total high time is then compared with the restart offset plus 36.

// File: rtl/rst_qual_pkg.sv
// Package: shared mode encoding and default timing constants for the
// reset qualification controller.
package rst_qual_pkg;

    // Selects how the minimum width of the external reset is measured.
    typedef enum logic {
        OSC_CYCLE = 1'b0,   // counted in machine-cycle strobes
        OSC_TIME  = 1'b1    // counted in reference-time ticks
    } osc_mode_e;

    localparam int DEF_CLK_PER_MC = 12;  // system clocks per machine cycle
    localparam int DEF_MC_QUAL    = 2;   // machine cycles needed to qualify
    localparam int DEF_REF_TICKS  = 4;   // 4 MHz ticks make 1 us
    localparam int DEF_WDT_MC     = 3;   // machine cycles of watchdog reset
    localparam int DEF_SYNC_STG   = 2;   // synchronizer depth

endpackage

// File: rtl/rst_in_sync.sv
// Module: rst_in_sync
// Brings an asynchronous level into the clk domain through a chain of
// STAGES flops. Assumes the input is already free of glitches (Schmitt
// cleaned), so only metastability has to be handled. The chain clears
// to 0 under the synchronous active-low reset.
module rst_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop: samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                // Later flops: pass the level one stage further on.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/rst_width_qual.sv
// Module: rst_width_qual
// Accepts a synchronized reset request only after it has stayed high
// for a minimum number of strobes. The mode input chooses both the
// strobe (machine cycle or reference tick) and the count target.
// Assumes each strobe is one clock wide. Any low level clears the count
// and the qualified state on the next edge.
module rst_width_qual
    import rst_qual_pkg::*;
#(
    parameter int MC_QUAL   = DEF_MC_QUAL,
    parameter int REF_TICKS = DEF_REF_TICKS
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_sync,
    input  osc_mode_e mode,
    input  logic      mc_tick,
    input  logic      ref_tick,
    output logic      qualified
);

    localparam int MAXC  = (MC_QUAL > REF_TICKS) ? MC_QUAL : REF_TICKS;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] MC_LAST  = CNT_W'(MC_QUAL - 1);
    localparam logic [CNT_W-1:0] REF_LAST = CNT_W'(REF_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             qual_q;
    logic             step;
    logic [CNT_W-1:0] last;

    // Pick the strobe and the final count for the current mode.
    always_comb begin
        if (mode == OSC_TIME) begin
            step = ref_tick;
            last = REF_LAST;
        end else begin
            step = mc_tick;
            last = MC_LAST;
        end
    end

    // Width counter: counts strobes while the request is high and
    // restarts from zero when the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            qual_q <= 1'b0;
        end else if (!req_sync) begin
            cnt_q  <= '0;
            qual_q <= 1'b0;
        end else if (!qual_q && step) begin
            if (cnt_q == last) begin
                cnt_q  <= '0;
                qual_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign qualified = qual_q;

endmodule

// File: rtl/rst_wdt_stretch.sv
// Module: rst_wdt_stretch
// Turns a one-clock watchdog overflow into a reset pulse that lasts
// exactly CLK_PER_MC*WDT_MC system clocks from the edge that samples the
// overflow. An overflow that arrives during the pulse reloads the count.
module rst_wdt_stretch
    import rst_qual_pkg::*;
#(
    parameter int CLK_PER_MC = DEF_CLK_PER_MC,
    parameter int WDT_MC     = DEF_WDT_MC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    output logic active
);

    localparam int WDT_CLKS = CLK_PER_MC * WDT_MC;
    localparam int CNT_W    = $clog2(WDT_CLKS);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WDT_CLKS - 1);

    logic [CNT_W-1:0] left_q;
    logic             act_q;

    // Pulse timer: loads on overflow and counts down to the end of the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            act_q  <= 1'b0;
        end else if (ovf) begin
            left_q <= LOAD;
            act_q  <= 1'b1;
        end else if (act_q) begin
            if (left_q == '0) act_q  <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    assign active = act_q;

endmodule

// File: rtl/rst_qual_ctrl.sv
// Module: rst_qual_ctrl (top)
// Combines a qualified external reset request with a stretched watchdog
// pulse into the core reset. The same signal goes out to peripherals,
// and it forces the bus-control strobes high while it is asserted.
// Assumes mc_tick, ref_tick and wdt_ovf are one-clock pulses in the clk
// domain and rst_in is asynchronous but free of glitches.
module rst_qual_ctrl
    import rst_qual_pkg::*;
#(
    parameter int CLK_PER_MC = DEF_CLK_PER_MC,
    parameter int MC_QUAL    = DEF_MC_QUAL,
    parameter int REF_TICKS  = DEF_REF_TICKS,
    parameter int WDT_MC     = DEF_WDT_MC,
    parameter int SYNC_STG   = DEF_SYNC_STG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_in,
    input  logic osc_sel,
    input  logic mc_tick,
    input  logic ref_tick,
    input  logic wdt_ovf,
    input  logic ale_core,
    input  logic psen_core,
    output logic cpu_rst,
    output logic rst_out,
    output logic ale_pin,
    output logic psen_pin
);

    logic      req_sync;
    logic      ext_rst;
    logic      wdt_active;
    osc_mode_e mode;

    assign mode = osc_mode_e'(osc_sel);

    rst_in_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rst_in),
        .sync_out (req_sync)
    );

    rst_width_qual #(.MC_QUAL(MC_QUAL), .REF_TICKS(REF_TICKS)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_sync  (req_sync),
        .mode      (mode),
        .mc_tick   (mc_tick),
        .ref_tick  (ref_tick),
        .qualified (ext_rst)
    );

    rst_wdt_stretch #(.CLK_PER_MC(CLK_PER_MC), .WDT_MC(WDT_MC)) u_wdt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovf    (wdt_ovf),
        .active (wdt_active)
    );

    // Merge the two sources and apply the strobe override.
    always_comb begin
        cpu_rst  = ext_rst | wdt_active;
        rst_out  = cpu_rst;
        ale_pin  = ale_core  | cpu_rst;
        psen_pin = psen_core | cpu_rst;
    end

endmodule

// File: rtl/rst_qual_ctrl_chk.sv
// Module: rst_qual_ctrl_chk
// Assertion checker bound into rst_qual_ctrl. It watches the boundaries
// between the synchronizer, the width qualifier and the watchdog stretcher.
module rst_qual_ctrl_chk #(
    parameter int WDT_CLKS = 36
) (
    input logic clk,
    input logic rst_n,
    input logic req_sync,
    input logic ext_rst,
    input logic wdt_ovf,
    input logic wdt_active,
    input logic cpu_rst,
    input logic ale_pin,
    input logic psen_pin
);

    int unsigned run_len;

    // Length of the current watchdog pulse since its last overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_len <= 0;
        else if (wdt_ovf)    run_len <= 0;
        else if (wdt_active) run_len <= run_len + 1;
        else                 run_len <= 0;
    end

    // R4
    ext_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_rst) |-> $past(req_sync));

    // R5
    ext_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_sync |=> !ext_rst);

    // R6
    wdt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf |=> wdt_active);

    // R6
    wdt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_active) |-> $past(wdt_ovf));

    // R7
    wdt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_active |-> (run_len < WDT_CLKS));

    // R9
    strobe_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst |-> (ale_pin && psen_pin));

endmodule

bind rst_qual_ctrl rst_qual_ctrl_chk #(.WDT_CLKS(CLK_PER_MC * WDT_MC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_sync   (req_sync),
    .ext_rst    (ext_rst),
    .wdt_ovf    (wdt_ovf),
    .wdt_active (wdt_active),
    .cpu_rst    (cpu_rst),
    .ale_pin    (ale_pin),
    .psen_pin   (psen_pin)
);

// File: tb/rst_qual_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench for rst_qual_ctrl: one task per scenario, each checking
// its own results at negative clock edges.
module rst_qual_ctrl_test;

    logic clk = 1'b0;
    logic rst_n, rst_in, osc_sel, mc_tick, ref_tick, wdt_ovf;
    logic ale_core, psen_core;
    logic cpu_rst, rst_out, ale_pin, psen_pin;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rst_qual_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rst_in(rst_in), .osc_sel(osc_sel),
        .mc_tick(mc_tick), .ref_tick(ref_tick), .wdt_ovf(wdt_ovf),
        .ale_core(ale_core), .psen_core(psen_core),
        .cpu_rst(cpu_rst), .rst_out(rst_out),
        .ale_pin(ale_pin), .psen_pin(psen_pin)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_mc();
        mc_tick = 1'b1; @(negedge clk); mc_tick = 1'b0;
    endtask

    task automatic pulse_ref();
        ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
    endtask

    task automatic drop_input();
        rst_in = 1'b0; cyc(5);
    endtask

    // R1: block reset clears outputs even with requests pending.
    task automatic t_reset();
        rst_n = 1'b0; rst_in = 1'b1; wdt_ovf = 1'b1;
        cyc(4);
        check("R1 cpu_rst in reset", cpu_rst, 0);
        check("R1 rst_out in reset", rst_out, 0);
        wdt_ovf = 1'b0; rst_in = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        check("R1 cpu_rst after reset", cpu_rst, 0);
    endtask

    // R2 R5 R8 R9: cycle-mode qualification, hold and release.
    task automatic t_cycle_mode();
        osc_sel = 1'b0;
        rst_in = 1'b1; cyc(2);
        pulse_mc();
        check("R2 one strobe no reset", cpu_rst, 0);
        ref_tick = 1'b1; cyc(6); ref_tick = 1'b0;
        check("R2 ref ticks ignored in cycle mode", cpu_rst, 0);
        pulse_mc();
        check("R2 second strobe asserts", cpu_rst, 1);
        check("R8 rst_out follows", rst_out, 1);
        ale_core = 1'b0; psen_core = 1'b0; #0;
        check("R9 ale forced", ale_pin, 1);
        check("R9 psen forced", psen_pin, 1);
        cyc(30);
        check("R5 held while input high", cpu_rst, 1);
        rst_in = 1'b0;
        cyc(1); check("R5 still high edge 1", cpu_rst, 1);
        cyc(1); check("R5 still high edge 2", cpu_rst, 1);
        cyc(1); check("R5 released edge 3", cpu_rst, 0);
        check("R8 rst_out released", rst_out, 0);
        cyc(2);
    endtask

    // R4: a short request restarts the count.
    task automatic t_short_pulse();
        osc_sel = 1'b0;
        rst_in = 1'b1; cyc(2);
        pulse_mc();
        rst_in = 1'b0; cyc(4);
        check("R4 no reset from short pulse", cpu_rst, 0);
        rst_in = 1'b1; cyc(2);
        pulse_mc();
        check("R4 count restarted", cpu_rst, 0);
        pulse_mc();
        check("R4 qualifies after full width", cpu_rst, 1);
        drop_input();
    endtask

    // R3: time-mode qualification, machine strobes ignored.
    task automatic t_time_mode();
        osc_sel = 1'b1;
        rst_in = 1'b1; cyc(2);
        for (int i = 0; i < 3; i++) pulse_mc();
        check("R3 mc strobes ignored", cpu_rst, 0);
        for (int i = 0; i < 3; i++) pulse_ref();
        check("R3 three ticks not enough", cpu_rst, 0);
        pulse_ref();
        check("R3 fourth tick asserts", cpu_rst, 1);
        drop_input();
        osc_sel = 1'b0;
    endtask

    // R6 R7: watchdog pulse length, with an optional restart.
    task automatic t_wdt(input int restart_at, input int exp_len, input string req);
        int hi = 0;
        bit done = 0;
        wdt_ovf = 1'b1;
        while (!done && hi < 300) begin
            @(negedge clk);
            if (cpu_rst) begin
                hi++;
                if (rst_out !== 1'b1) check("R8 rst_out during wdt", rst_out, 1);
            end else begin
                done = 1;
            end
            wdt_ovf = (restart_at != 0 && hi == restart_at) ? 1'b1 : 1'b0;
        end
        check(req, hi, exp_len);
        cyc(3);
    endtask

    // R9: pass-through of strobes when no reset is active.
    task automatic t_passthru();
        ale_core = 1'b1; psen_core = 1'b0; #1;
        check("R9 ale passes", ale_pin, 1);
        check("R9 psen passes", psen_pin, 0);
        ale_core = 1'b0; psen_core = 1'b1; #1;
        check("R9 ale passes low", ale_pin, 0);
        check("R9 psen passes high", psen_pin, 1);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; rst_in = 1'b0; osc_sel = 1'b0;
        mc_tick = 1'b0; ref_tick = 1'b0; wdt_ovf = 1'b0;
        ale_core = 1'b0; psen_core = 1'b0;
        @(negedge clk);
        t_reset();
        t_passthru();
        t_cycle_mode();
        t_short_pulse();
        t_time_mode();
        t_wdt(0, 36, "R6 watchdog pulse length");
        t_wdt(20, 56, "R7 watchdog restart length");
        t_passthru();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule